// File: doc/BRIEF.md
# Reconfigurable Multiprecision Unsigned Multiplier

This block multiplies two unsigned integers at a precision chosen per transaction: one 8x8 product, two independent 8x8 products in parallel, one 16x16 product, or one full 32x32 product. A single grid of 8x8 sub-multipliers does all of this. The chosen mode enables the sub-multipliers it needs and forces the operands of the rest to zero, so the unused ones do not toggle. A narrow product does not need a separate narrow multiplier.

The partial products are laid into non-overlapping row vectors and summed with parallel-prefix (Kogge-Stone) adders. The datapath has one input register stage and one output register stage. A transaction offered with `in_valid` produces its result with `out_valid` exactly two clock edges later. A new transaction may be offered on every cycle, in any mix of modes.

Top module: `mpm_top`

## Requirements
- R1: A transaction sampled with `in_valid` high on clock edge k drives `out_valid` high after edge k+2 for exactly one cycle per transaction. Back-to-back transactions yield back-to-back results in order. `out_valid` is low whenever no transaction is two edges old.
- R2: While reset is asserted, `out_valid` and `product` are zero.
- R3: Mode code 2'b00 (single 8-bit) gives `product` = A[7:0]*B[7:0] with bits 63:16 zero. Operand bits above bit 7 have no effect.
- R4: Mode code 2'b01 (twin 8-bit) gives `product[15:0]` = A[7:0]*B[7:0] and `product[31:16]` = A[15:8]*B[15:8], with bits 63:32 zero. Operand bits above bit 15 have no effect, and neither lane carries into the other.
- R5: Mode code 2'b10 (16-bit) gives `product` = A[15:0]*B[15:0] with bits 63:32 zero. Operand bits above bit 15 have no effect.
- R6: Mode code 2'b11 (32-bit) gives the full 64-bit `product` = A*B.
- R7: On cycles where `out_valid` is low, `product` keeps the value of the most recent result (zero after reset).
- R8: All-ones and zero operands give exact results in every mode. For example, in 32-bit mode 0xFFFFFFFF * 0xFFFFFFFF = 0xFFFFFFFE00000001, and in twin mode all-ones gives 0x00000000FE01FE01.
- R9: Each result uses the mode that was presented with its own operands, even when the mode changes on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands and mode are offered this cycle |
| mode | input | 2 | Precision code: 00 single 8, 01 twin 8, 10 16-bit, 11 32-bit |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| out_valid | output | 1 | `product` holds a new result this cycle |
| product | output | 64 | Result field (two 16-bit lanes in twin mode) |

## Verification
The hardest case to reach is a pipeline whose input stage holds a different mode from the one just leaving the output stage. In that case the enable mask of the sub-multiplier grid is rebuilt on every cycle. The bench offers long uninterrupted runs of transactions with a random mode on each cycle, and it sets every operand bit, including the bits the chosen mode must ignore. This exposes any mask that lags by a cycle or any lane that leaks into its neighbour. All-ones operands in twin mode load both lanes to their maximum, so a carry across the lane boundary would show at bit 16.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  typedef enum logic [1:0] {
    MODE_S8  = 2'b00,
    MODE_T8  = 2'b01,
    MODE_S16 = 2'b10,
    MODE_S32 = 2'b11
  } mpm_mode_e;

  // Decide whether sub-multiplier (row, col) takes part in a given mode.
  // row indexes the chunk of operand A, col the chunk of operand B.
  function automatic logic sub_enabled(input logic [1:0] md, input int row,
                                       input int col, input int half_chunks);
    logic r;
    case (md)
      MODE_S8:  r = (row == 0) && (col == 0);
      MODE_T8:  r = (row == col) && (row < 2);
      MODE_S16: r = (row < half_chunks) && (col < half_chunks);
      default:  r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mpm_sub_mul.sv
module mpm_sub_mul #(
  parameter int SUB_W = 8
) (
  input  logic               en,
  input  logic [SUB_W-1:0]   x,
  input  logic [SUB_W-1:0]   y,
  output logic [2*SUB_W-1:0] p
);
  logic [SUB_W-1:0] x_g;
  logic [SUB_W-1:0] y_g;

  // Operand isolation: an idle element sees constant zero inputs.
  assign x_g = x & {SUB_W{en}};
  assign y_g = y & {SUB_W{en}};
  assign p   = {{SUB_W{1'b0}}, x_g} * {{SUB_W{1'b0}}, y_g};
endmodule

// File: rtl/mpm_ks_add.sv
module mpm_ks_add #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         cout
);
  localparam int LV = $clog2(W);

  logic [W-1:0] gen [LV+1];
  logic [W-1:0] prp [LV+1];

  assign gen[0] = x & y;
  assign prp[0] = x ^ y;

  generate
    for (genvar l = 1; l <= LV; l++) begin : g_lvl
      localparam int D = 1 << (l - 1);
      for (genvar i = 0; i < W; i++) begin : g_bit
        if (i >= D) begin : g_black
          // group generate / propagate from the high and low spans
          assign gen[l][i] = gen[l-1][i] | (prp[l-1][i] & gen[l-1][i-D]);
          assign prp[l][i] = prp[l-1][i] & prp[l-1][i-D];
        end else begin : g_pass
          assign gen[l][i] = gen[l-1][i];
          assign prp[l][i] = prp[l-1][i];
        end
      end
    end
  endgenerate

  assign s    = prp[0] ^ {gen[LV][W-2:0], 1'b0};
  assign cout = gen[LV][W-1] | (&prp[LV]);
endmodule

// File: rtl/mpm_array.sv
module mpm_array #(
  parameter int SUB_W = 8,
  parameter int N     = 4
) (
  input  logic [1:0]           md,
  input  logic [N*SUB_W-1:0]   a,
  input  logic [N*SUB_W-1:0]   b,
  output logic [2*N*SUB_W-1:0] prod
);
  import mpm_pkg::*;

  localparam int PW   = 2 * N * SUB_W;
  localparam int HALF = (N > 1) ? N / 2 : 1;

  logic [2*SUB_W-1:0] pp [N][N];
  logic [PW-1:0]      row_e [N];
  logic [PW-1:0]      row_o [N];
  logic [PW-1:0]      row_s [N];
  logic [PW-1:0]      row_sh [N];
  logic [PW-1:0]      acc [N];
  logic [N-1:0]       row_co;
  logic [N-1:0]       acc_co;

  generate
    for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
        logic en_ij;
        assign en_ij = sub_enabled(md, i, j, HALF);
        mpm_sub_mul #(.SUB_W(SUB_W)) u_sub (
          .en (en_ij),
          .x  (a[i*SUB_W +: SUB_W]),
          .y  (b[j*SUB_W +: SUB_W]),
          .p  (pp[i][j])
        );
      end
    end
  endgenerate

  // Even and odd columns of a row never overlap, so each row needs one add.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      row_e[i] = '0;
      row_o[i] = '0;
      for (int j = 0; j < N; j++) begin
        if ((j % 2) == 0) row_e[i][j*SUB_W +: 2*SUB_W] = pp[i][j];
        else              row_o[i][j*SUB_W +: 2*SUB_W] = pp[i][j];
      end
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_rsum
      mpm_ks_add #(.W(PW)) u_row_add (
        .x    (row_e[i]),
        .y    (row_o[i]),
        .s    (row_s[i]),
        .cout (row_co[i])
      );
      assign row_sh[i] = row_s[i] << (i * SUB_W);
    end

    assign acc[0]    = row_sh[0];
    assign acc_co[0] = row_co[0];
    for (genvar i = 1; i < N; i++) begin : g_acc
      mpm_ks_add #(.W(PW)) u_acc_add (
        .x    (acc[i-1]),
        .y    (row_sh[i]),
        .s    (acc[i]),
        .cout (acc_co[i])
      );
    end
  endgenerate

  assign prod = acc[N-1];
endmodule

// File: rtl/mpm_top.sv
module mpm_top #(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          mode,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  output logic                out_valid,
  output logic [2*DATA_W-1:0] product
);
  localparam int N  = DATA_W / SUB_W;
  localparam int PW = 2 * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_q = rst_pipe_q[1];

  // stage 1: operand capture
  logic              vld1_q, vld1_d;
  logic [1:0]        md1_q, md1_d;
  logic [DATA_W-1:0] a1_q, a1_d, b1_q, b1_d;

  always_comb begin
    vld1_d = in_valid;
    md1_d  = md1_q;
    a1_d   = a1_q;
    b1_d   = b1_q;
    if (in_valid) begin
      md1_d = mode;
      a1_d  = op_a;
      b1_d  = op_b;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      vld1_q <= 1'b0;
      md1_q  <= '0;
      a1_q   <= '0;
      b1_q   <= '0;
    end else begin
      vld1_q <= vld1_d;
      md1_q  <= md1_d;
      a1_q   <= a1_d;
      b1_q   <= b1_d;
    end
  end

  // reconfigurable array
  logic [PW-1:0] prod_c;

  mpm_array #(.SUB_W(SUB_W), .N(N)) u_array (
    .md   (md1_q),
    .a    (a1_q),
    .b    (b1_q),
    .prod (prod_c)
  );

  // stage 2: result register
  logic          vld2_q, vld2_d;
  logic [PW-1:0] prod2_q, prod2_d;

  always_comb begin
    vld2_d  = vld1_q;
    prod2_d = prod2_q;
    if (vld1_q) prod2_d = prod_c;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      vld2_q  <= 1'b0;
      prod2_q <= '0;
    end else begin
      vld2_q  <= vld2_d;
      prod2_q <= prod2_d;
    end
  end

  assign out_valid = vld2_q;
  assign product   = prod2_q;
endmodule

// File: rtl/mpm_checker.sv
module mpm_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                srst_n,
  input logic                in_valid,
  input logic [1:0]          mode,
  input logic [DATA_W-1:0]   op_a,
  input logic [DATA_W-1:0]   op_b,
  input logic                out_valid,
  input logic [2*DATA_W-1:0] product
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)          age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!srst_n)
    (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));             // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (age_q != 2'd0 && !out_valid) |-> $stable(product));               // R7

  AST_S8_UPPER_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (age_q == 2'd2 && out_valid && $past(mode, 2) == 2'b00)
      |-> (product[2*DATA_W-1:16] == '0));                             // R3

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (age_q == 2'd2 && out_valid && ($past(mode, 2) == 2'b01 || $past(mode, 2) == 2'b10))
      |-> (product[2*DATA_W-1:32] == '0));                             // R5

  AST_TWIN_LOW_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (age_q == 2'd2 && out_valid && $past(mode, 2) == 2'b01 && $past(op_a[7:0], 2) == 8'd0)
      |-> (product[15:0] == 16'd0));                                   // R4

  AST_FULL_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!srst_n)
    (age_q == 2'd2 && out_valid && $past(mode, 2) == 2'b11 && $past(op_b, 2) == '0)
      |-> (product == '0));                                            // R8
endmodule

bind mpm_top mpm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .srst_n    (rst_sync_q),
  .in_valid  (in_valid),
  .mode      (mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .product   (product)
);

// File: tb/mpm_top_tb.sv
module mpm_top_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        out_valid;
  logic [63:0] product;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  bit mon_on   = 0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  mpm_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  function automatic logic [63:0] ref_mul(input logic [1:0] m,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r;
    case (m)
      2'b00: r = {48'd0, ({8'd0, a[7:0]} * {8'd0, b[7:0]})};
      2'b01: r = {32'd0, ({8'd0, a[15:8]} * {8'd0, b[15:8]}),
                         ({8'd0, a[7:0]} * {8'd0, b[7:0]})};
      2'b10: r = {32'd0, ({16'd0, a[15:0]} * {16'd0, b[15:0]})};
      default: r = {32'd0, a} * {32'd0, b};
    endcase
    return r;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    mode     = m;
    op_a     = a;
    op_b     = b;
    it.exp   = ref_mul(m, a, b);
    it.tag   = (tag == "") ? mode_tag(m) : tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a     = $urandom;
      op_b     = $urandom;
      mode     = 2'($urandom);
    end
  endtask

  // Monitor / scoreboard
  logic [63:0] last_prod;
  initial begin
    last_prod = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (out_valid) begin
          if (sb_q.size() == 0) begin
            check("R1 unexpected out_valid", 64'd1, 64'd0);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, product, it.exp);
          end
          last_prod = product;
        end else begin
          check("R7 hold", product, last_prod);   // R7
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0;
    mode     = 2'b00;
    op_a     = '0;
    op_b     = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R2 product in reset", product, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 out_valid after reset", {63'd0, out_valid}, 64'd0);
    mon_on = 1'b1;

    // R1: two-cycle latency on an isolated transaction
    drive(2'b11, 32'd1234567, 32'd7654321, "");
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid one edge after", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R1 out_valid two edges after", {63'd0, out_valid}, 64'd1);
    idle(3);

    // R3/R4/R5: bits outside the chosen width are set and must be ignored
    drive(2'b00, 32'hDEAD_BE05, 32'hFFFF_FF07, "R3 upper bits ignored");
    drive(2'b01, 32'hABCD_1234, 32'h5555_5678, "R4 upper bits ignored");
    drive(2'b10, 32'hFFFF_00FF, 32'h8000_0101, "R5 upper bits ignored");
    idle(4);

    // R8: all-ones and zero corners in every mode
    for (int m = 0; m < 4; m++) begin
      drive(2'(m), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 all ones");
      drive(2'(m), 32'h0000_0000, 32'hFFFF_FFFF, "R8 zero a");
      drive(2'(m), 32'hFFFF_FFFF, 32'h0000_0000, "R8 zero b");
    end
    // R4: full lower lane next to empty upper lane, and the reverse
    drive(2'b01, 32'h0000_00FF, 32'h0000_00FF, "R4 lane boundary low");
    drive(2'b01, 32'h0000_FF00, 32'h0000_FF00, "R4 lane boundary high");
    idle(4);

    // R6: single 32-bit operands with one bit set
    for (int k = 0; k < 32; k += 7)
      drive(2'b11, 32'd1 << k, 32'hFFFF_FFFF, "R6 walking bit");
    idle(4);

    // R9: back-to-back random mode per cycle
    for (int k = 0; k < 400; k++)
      drive(2'($urandom), $urandom, $urandom, "");
    idle(3);

    // R9: bursts with gaps
    for (int k = 0; k < 60; k++) begin
      drive(2'($urandom), $urandom, $urandom, "");
      drive(2'($urandom), $urandom, $urandom, "");
      idle(1 + ($urandom % 3));
    end
    idle(6);

    // R1: every result produced, none pending
    check("R1 scoreboard drained", 64'(sb_q.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule